// File: doc/BRIEF.md
# ADC Scan Sequencer

This block plans the conversions of a successive-approximation converter core across several analog inputs. Software programs an ordered list of channel numbers, a sequence length, a per-channel sampling-time code and a trigger source. When the selected trigger fires, the sequencer walks the list. For each entry it presents the channel number and the decoded sample-cycle count to the converter core and pulses a launch strobe. It then waits for the core's done strobe and captures the 12-bit result.

Each captured result goes into a single data register. An end-of-conversion flag marks a fresh value, and an overrun flag marks a value that replaced one nobody had read. A one-cycle request pulse accompanies every captured result so that a transfer engine can drain the register. Register decoding, the transfer engine and the analog multiplexer sit outside the block.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `eoc_o`, `ovr_o`, `dma_req_o`, `busy_o` and `conv_start_o` are 0 and `data_o` is 0.
- R2: A recognized trigger launches the channel in list entry 0 (bits [3:0] of `seq_list_i`); entry k sits in bits [4k+3:4k]. With `scan_en_i`=1, entries 0 to `seq_len_i` are converted in ascending entry order, so a length of 0 gives one conversion.
- R3: With `scan_en_i`=0, each trigger converts only list entry 0, whatever `seq_len_i` holds.
- R4: While `conv_start_o` is high, `conv_smp_cyc_o` equals the cycle count for the code in bits [3c+2:3c] of `smp_code_i`, where c is `conv_ch_o`. Codes 0 to 7 give 3, 15, 28, 56, 84, 112, 144 and 480 cycles.
- R5: `trig_src_i` selects the trigger source, and the sources not selected have no effect:
  - 0: `sw_start_i` high at a clock edge.
  - 1: a rising edge of `tmr_evt_i`, seen one edge after the input rises.
  - 2: a rising edge of `ext_trig_i`, taken through a two-flop synchronizer. If the pin is high from edge A on, `conv_start_o` rises after edge A+2.
  - 3: no trigger.
- R6: `busy_o` is high from the trigger edge until the edge that captures the last result. Triggers arriving while it is high are ignored.
- R7: At the edge where `conv_done_i` is seen during a conversion, `data_o` takes `conv_data_i`, `eoc_o` is set, and `dma_req_o` is high for exactly the following cycle.
- R8: A `data_rd_i` strobe clears `eoc_o` and `ovr_o` at the next edge. If a result lands at that same edge, `eoc_o` stays set and `ovr_o` stays clear.
- R9: A result that lands while `eoc_o` is set and no read is strobed sets `ovr_o`.
- R10: `conv_start_o` is a one-cycle pulse. It rises the cycle after the trigger edge, and again the cycle after each captured result that is not the last of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_src_i | input | 2 | Trigger source select (0 software, 1 timer, 2 pin, 3 none) |
| sw_start_i | input | 1 | Software start strobe |
| tmr_evt_i | input | 1 | Timer event level, edge detected |
| ext_trig_i | input | 1 | Asynchronous external trigger pin |
| scan_en_i | input | 1 | Convert the whole list when 1, only entry 0 when 0 |
| seq_len_i | input | 3 | Last list entry index in scan mode |
| seq_list_i | input | 32 | Eight 4-bit channel numbers, entry 0 in the low bits |
| smp_code_i | input | 48 | Sixteen 3-bit sampling-time codes, channel 0 in the low bits |
| conv_ch_o | output | 4 | Channel presented to the converter core |
| conv_smp_cyc_o | output | 9 | Sample-and-hold cycle count for that channel |
| conv_start_o | output | 1 | Launch strobe to the converter core |
| conv_done_i | input | 1 | Converter core finished strobe |
| conv_data_i | input | 12 | Converter core result |
| data_o | output | 12 | Data register |
| data_rd_i | input | 1 | Data register read strobe |
| eoc_o | output | 1 | End-of-conversion flag |
| ovr_o | output | 1 | Overrun flag |
| dma_req_o | output | 1 | One-cycle request per captured result |
| busy_o | output | 1 | Sequence in progress |

## Verification
- **Launch timing.** A software trigger is due as a launch strobe in the cycle right after the edge that samples it, and so is a timer edge. A pin edge arrives two edges later because of the synchronizer.
- **Result timing.** A captured result shows up on `data_o`, `eoc_o` and `dma_req_o` one cycle after the done strobe is sampled. The next launch strobe follows in that same cycle.
- **How the bench keeps to this.** The bench drives every input between edges and records what was held at each edge. Its behavioural model then advances once per edge and predicts all outputs for the cycle that follows. Every output is compared with the model at the falling edge of every cycle, so a strobe that arrives one cycle early or late is reported.
- **Converter stand-in.** The bench also plays the converter core, with a latency that varies per channel. On each launch it checks the presented channel and cycle count against its own table.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int SMP_CODE_W = 3;
  localparam int SMP_CNT_W  = 9;

  typedef enum logic [1:0] {
    TRIG_SW  = 2'd0,
    TRIG_TMR = 2'd1,
    TRIG_EXT = 2'd2,
    TRIG_OFF = 2'd3
  } trig_src_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_LAUNCH = 2'd1,
    SQ_WAIT   = 2'd2
  } seq_state_e;

  // Sampling-time code to sample-and-hold cycle count.
  function automatic logic [SMP_CNT_W-1:0] smp_cycles(input logic [SMP_CODE_W-1:0] code);
    logic [SMP_CNT_W-1:0] cyc;
    case (code)
      3'd0:    cyc = 9'd3;
      3'd1:    cyc = 9'd15;
      3'd2:    cyc = 9'd28;
      3'd3:    cyc = 9'd56;
      3'd4:    cyc = 9'd84;
      3'd5:    cyc = 9'd112;
      3'd6:    cyc = 9'd144;
      default: cyc = 9'd480;
    endcase
    return cyc;
  endfunction

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_scan_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel_i,
  input  logic       sw_start_i,
  input  logic       tmr_evt_i,
  input  logic       ext_pin_i,
  output logic       fire_o
);

  logic [SYNC_STAGES-1:0] ext_sync_q;
  logic                   ext_prev_q;
  logic                   tmr_prev_q;
  logic                   tmr_rise;
  logic                   ext_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_sync_q <= '0;
      ext_prev_q <= 1'b0;
      tmr_prev_q <= 1'b0;
    end else begin
      ext_sync_q <= {ext_sync_q[SYNC_STAGES-2:0], ext_pin_i};
      ext_prev_q <= ext_sync_q[SYNC_STAGES-1];
      tmr_prev_q <= tmr_evt_i;
    end
  end

  assign tmr_rise = tmr_evt_i & ~tmr_prev_q;
  assign ext_rise = ext_sync_q[SYNC_STAGES-1] & ~ext_prev_q;

  always_comb begin
    case (trig_src_e'(src_sel_i))
      TRIG_SW:  fire_o = sw_start_i;
      TRIG_TMR: fire_o = tmr_rise;
      TRIG_EXT: fire_o = ext_rise;
      default:  fire_o = 1'b0;
    endcase
  end

  // R5
  off_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_i == TRIG_OFF) |-> !fire_o);

  // R5
  tmr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_i == TRIG_TMR && tmr_evt_i && $stable(tmr_evt_i)) |-> !fire_o);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_scan_pkg::*;
#(
  parameter int LIST_LEN = 8,
  parameter int CH_W     = 4,
  parameter int IDX_W    = $clog2(LIST_LEN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LIST_LEN*CH_W-1:0] list_i,
  input  logic [IDX_W-1:0]         len_i,
  input  logic                     scan_en_i,
  input  logic                     fire_i,
  input  logic                     conv_done_i,
  output logic                     busy_o,
  output logic                     launch_o,
  output logic [CH_W-1:0]          ch_o,
  output logic                     accept_o
);

  seq_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;
  logic             at_last;

  assign last_idx = scan_en_i ? len_i : '0;
  assign at_last  = (idx_q == last_idx);
  assign busy_o   = (st_q != SQ_IDLE);
  assign launch_o = (st_q == SQ_LAUNCH);
  assign accept_o = (st_q == SQ_WAIT) && conv_done_i;
  assign ch_o     = list_i[idx_q*CH_W +: CH_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      idx_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (fire_i) begin
            st_q  <= SQ_LAUNCH;
            idx_q <= '0;
          end
        end
        SQ_LAUNCH: st_q <= SQ_WAIT;
        SQ_WAIT: begin
          if (conv_done_i) begin
            if (at_last) begin
              st_q  <= SQ_IDLE;
              idx_q <= '0;
            end else begin
              st_q  <= SQ_LAUNCH;
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // R10
  launch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |=> !launch_o);

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_WAIT && !conv_done_i) |=> (busy_o && !launch_o));

  // R2
  first_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && fire_i) |=> (launch_o && ch_o == list_i[CH_W-1:0]));

  // R3
  single_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && !scan_en_i) |=> !busy_o);

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             land_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             rd_i,
  output logic [RES_W-1:0] data_o,
  output logic             eoc_o,
  output logic             ovr_o,
  output logic             dma_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_o <= '0;
      eoc_o  <= 1'b0;
      ovr_o  <= 1'b0;
      dma_o  <= 1'b0;
    end else if (land_i) begin
      data_o <= data_i;
      eoc_o  <= 1'b1;
      ovr_o  <= rd_i ? 1'b0 : (ovr_o | eoc_o);
      dma_o  <= 1'b1;
    end else begin
      dma_o <= 1'b0;
      if (rd_i) begin
        eoc_o <= 1'b0;
        ovr_o <= 1'b0;
      end
    end
  end

  // R7
  land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    land_i |=> (eoc_o && dma_o && data_o == $past(data_i)));

  // R7
  dma_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_o && !land_i) |=> !dma_o);

  // R8
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !land_i) |=> (!eoc_o && !ovr_o));

  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (land_i && eoc_o && !rd_i) |=> ovr_o);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int LIST_LEN = 8,
  parameter int RES_W    = 12,
  parameter int CH_W     = $clog2(NUM_CH),
  parameter int IDX_W    = $clog2(LIST_LEN)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   trig_src_i,
  input  logic                         sw_start_i,
  input  logic                         tmr_evt_i,
  input  logic                         ext_trig_i,
  input  logic                         scan_en_i,
  input  logic [IDX_W-1:0]             seq_len_i,
  input  logic [LIST_LEN*CH_W-1:0]     seq_list_i,
  input  logic [NUM_CH*SMP_CODE_W-1:0] smp_code_i,
  output logic [CH_W-1:0]              conv_ch_o,
  output logic [SMP_CNT_W-1:0]         conv_smp_cyc_o,
  output logic                         conv_start_o,
  input  logic                         conv_done_i,
  input  logic [RES_W-1:0]             conv_data_i,
  output logic [RES_W-1:0]             data_o,
  input  logic                         data_rd_i,
  output logic                         eoc_o,
  output logic                         ovr_o,
  output logic                         dma_req_o,
  output logic                         busy_o
);

  // Named internal events
  logic                  trig_fire;
  logic                  result_land;
  logic [SMP_CODE_W-1:0] cur_code;

  adc_trig_sel #(.SYNC_STAGES(2)) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel_i  (trig_src_i),
    .sw_start_i (sw_start_i),
    .tmr_evt_i  (tmr_evt_i),
    .ext_pin_i  (ext_trig_i),
    .fire_o     (trig_fire)
  );

  adc_seq_ctrl #(.LIST_LEN(LIST_LEN), .CH_W(CH_W), .IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .list_i      (seq_list_i),
    .len_i       (seq_len_i),
    .scan_en_i   (scan_en_i),
    .fire_i      (trig_fire),
    .conv_done_i (conv_done_i),
    .busy_o      (busy_o),
    .launch_o    (conv_start_o),
    .ch_o        (conv_ch_o),
    .accept_o    (result_land)
  );

  assign cur_code       = smp_code_i[conv_ch_o*SMP_CODE_W +: SMP_CODE_W];
  assign conv_smp_cyc_o = smp_cycles(cur_code);

  adc_result_reg #(.RES_W(RES_W)) u_res (
    .clk    (clk),
    .rst_n  (rst_n),
    .land_i (result_land),
    .data_i (conv_data_i),
    .rd_i   (data_rd_i),
    .data_o (data_o),
    .eoc_o  (eoc_o),
    .ovr_o  (ovr_o),
    .dma_o  (dma_req_o)
  );

  // R4
  smp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> (conv_smp_cyc_o >= 9'd3 && conv_smp_cyc_o <= 9'd480));

  // R7
  land_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_land |-> busy_o);

endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  trig_src = 2'd0;
  logic        sw_start = 1'b0, tmr_evt = 1'b0, ext_trig = 1'b0;
  logic        scan_en = 1'b0;
  logic [2:0]  seq_len = 3'd0;
  logic [31:0] seq_list = '0;
  logic [47:0] smp_code = '0;
  logic [3:0]  conv_ch;
  logic [8:0]  conv_smp_cyc;
  logic        conv_start;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic [11:0] data;
  logic        data_rd = 1'b0;
  logic        eoc, ovr, dma_req, busy;

  always #10 clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .trig_src_i(trig_src), .sw_start_i(sw_start),
    .tmr_evt_i(tmr_evt), .ext_trig_i(ext_trig), .scan_en_i(scan_en),
    .seq_len_i(seq_len), .seq_list_i(seq_list), .smp_code_i(smp_code),
    .conv_ch_o(conv_ch), .conv_smp_cyc_o(conv_smp_cyc), .conv_start_o(conv_start),
    .conv_done_i(conv_done), .conv_data_i(conv_data), .data_o(data),
    .data_rd_i(data_rd), .eoc_o(eoc), .ovr_o(ovr), .dma_req_o(dma_req), .busy_o(busy)
  );

  int checks = 0, errors = 0, cyc = 0, starts = 0;
  int q[$];
  bit m_busy = 0, m_eoc = 0, m_ovr = 0, m_dma = 0, auto_rd = 0;
  int m_data = 0;
  bit h0 = 0, h1 = 0, h2 = 0, h3 = 0, t_prev = 0;
  int core_cnt = -1, core_ch = 0, serial = 5;
  int list_arr[8] = '{3, 7, 0, 15, 1, 2, 5, 9};

  function automatic int cyc_of_code(int code);
    int tab[8] = '{3, 15, 28, 56, 84, 112, 144, 480};
    return tab[code];
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic tick();
    bit sw_h = sw_start, tm_h = tmr_evt, ex_h = ext_trig, rd_h = data_rd, dn_h = conv_done;
    int dd_h = int'(conv_data);
    bit was_busy, trig_ev, exp_start;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (cyc > 100000) begin
      chk(0, "R6", "watchdog expired", cyc, 100000);
      finish_run();
    end
    h3 = h2; h2 = h1; h1 = h0; h0 = ex_h;
    case (trig_src)
      2'd0: trig_ev = sw_h;
      2'd1: trig_ev = tm_h && !t_prev;
      2'd2: trig_ev = h2 && !h3;
      default: trig_ev = 0;
    endcase
    t_prev = tm_h;
    was_busy = m_busy;
    exp_start = 0;
    if (dn_h) begin
      m_ovr = rd_h ? 0 : (m_ovr || m_eoc);
      m_eoc = 1; m_data = dd_h; m_dma = 1;
      if (m_busy) begin
        if (q.size() == 0) m_busy = 0;
        else exp_start = 1;
      end
    end else begin
      m_dma = 0;
      if (rd_h) begin m_eoc = 0; m_ovr = 0; end
    end
    if (trig_ev && !was_busy) begin
      q.delete();
      for (int i = 0; i <= (scan_en ? int'(seq_len) : 0); i++) q.push_back(list_arr[i]);
      m_busy = 1;
      exp_start = 1;
    end
    chk(conv_start == exp_start, "R10", "launch strobe", conv_start, exp_start);
    chk(busy == m_busy, "R6", "busy", busy, m_busy);
    chk(eoc == m_eoc, "R8", "eoc flag", eoc, m_eoc);
    chk(ovr == m_ovr, "R9", "overrun flag", ovr, m_ovr);
    chk(dma_req == m_dma, "R7", "request pulse", dma_req, m_dma);
    chk(int'(data) == m_data, "R7", "data register", data, m_data);
    // stand-in converter core
    conv_done = 0;
    if (core_cnt > 0) begin
      core_cnt--;
      if (core_cnt == 0) begin
        conv_done = 1;
        conv_data = 12'((core_ch << 8) | (serial & 255));
        serial += 37;
        core_cnt = -1;
      end
    end
    if (conv_start) begin
      if (q.size() > 0) begin
        chk(int'(conv_ch) == q[0], "R2", "channel order", conv_ch, q[0]);
        chk(int'(conv_smp_cyc) == cyc_of_code((q[0] * 5) % 8), "R4", "sample cycles",
            conv_smp_cyc, cyc_of_code((q[0] * 5) % 8));
        core_ch = q.pop_front();
      end else begin
        chk(0, "R3", "unexpected launch", 1, 0);
      end
      core_cnt = 2 + (core_ch % 3);
      starts++;
    end
    data_rd = auto_rd && m_eoc;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 400; g++) begin
      tick();
      if (!m_busy && core_cnt < 0 && !conv_done) break;
    end
    tick(); tick();
  endtask

  task automatic pulse_sw();
    sw_start = 1; tick(); sw_start = 0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) seq_list[i*4 +: 4] = 4'(list_arr[i]);
    for (int c = 0; c < 16; c++) smp_code[c*3 +: 3] = 3'((c * 5) % 8);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(eoc == 0 && ovr == 0 && dma_req == 0, "R1", "flags after reset", {eoc, ovr, dma_req}, 0);
    chk(busy == 0 && conv_start == 0 && data == 0, "R1", "idle after reset", {busy, conv_start}, 0);

    // R2 R7: software trigger, scan of 4 entries, reads as results land
    trig_src = 2'd0; scan_en = 1; seq_len = 3'd3; auto_rd = 1;
    starts = 0; pulse_sw(); wait_idle();
    chk(starts == 4, "R2", "conversions in scan", starts, 4);

    // R6: second software start while busy is ignored
    seq_len = 3'd7; starts = 0;
    pulse_sw(); tick(); tick(); pulse_sw(); tick(); pulse_sw(); wait_idle();
    chk(starts == 8, "R6", "conversions with extra triggers", starts, 8);

    // R3 R5: timer source, scan off; software strobe ignored
    trig_src = 2'd1; scan_en = 0; starts = 0;
    pulse_sw(); tick(); tick();
    chk(starts == 0, "R5", "software strobe under timer select", starts, 0);
    tmr_evt = 1; tick(); tick(); tick(); tmr_evt = 0; wait_idle();
    chk(starts == 1, "R3", "single conversion with scan off", starts, 1);

    // R5: external pin with synchronizer, full list; timer edges ignored
    trig_src = 2'd2; scan_en = 1; seq_len = 3'd7; starts = 0;
    tmr_evt = 1; tick(); tmr_evt = 0; tick(); tick();
    chk(starts == 0, "R5", "timer edge under pin select", starts, 0);
    ext_trig = 1; tick(); tick(); tick(); tick(); ext_trig = 0; wait_idle();
    chk(starts == 8, "R5", "pin-triggered scan", starts, 8);

    // R5: no source selected
    trig_src = 2'd3; starts = 0;
    pulse_sw(); tmr_evt = 1; ext_trig = 1; repeat (6) tick(); tmr_evt = 0; ext_trig = 0;
    repeat (4) tick();
    chk(starts == 0, "R5", "no source selected", starts, 0);

    // R9: results left unread cause overrun
    trig_src = 2'd0; auto_rd = 0; seq_len = 3'd2; starts = 0;
    pulse_sw(); wait_idle();
    chk(ovr == 1 && eoc == 1, "R9", "overrun after unread results", {eoc, ovr}, 3);

    // R8: read clears both flags
    data_rd = 1; tick(); data_rd = 0; tick();
    chk(ovr == 0 && eoc == 0, "R8", "flags after read", {eoc, ovr}, 0);

    // R8: length 0 scan with reads; results and reads may coincide
    auto_rd = 1; seq_len = 3'd0; starts = 0;
    pulse_sw(); wait_idle();
    chk(starts == 1, "R2", "length zero gives one conversion", starts, 1);
    seq_len = 3'd5; pulse_sw(); wait_idle();
    chk(q.size() == 0, "R2", "all list entries launched", q.size(), 0);

    finish_run();
  end

endmodule